// File: doc/BRIEF.md
# Sleep-Domain Wakeup Pin Monitor

This block sits in the always-on domain and watches a configurable set of external wakeup pins while the main processor is powered down. Each pin has its own trigger setting: rising edge, falling edge, both edges, or a level of selectable sense. Every qualifying event is captured in a sticky status bit. The host sees an interrupt for any captured pin that is also enabled. The block also gives one wake pulse for the first new enabled event after the host arms it for sleep.

The host reaches the block through a simple 32-bit word port. The port has a write strobe, a byte address, write data and a combinational read-data path. Two general-purpose timer words sit at the bottom of the map. Above them are five banks of equal length: enable, falling-edge, rising-edge, polarity and status. Before sleeping, the host clears the status words and pulses the sleep request.

Top module: `slp_wake_mon`

## Requirements
- R1: With n = ceil(NUM_PINS/32) words per bank, word `i` of bank `b` sits at byte address (b*n + i + 2)*4. The banks are numbered enable=0, falling=1, rising=2, polarity=3, status=4. The timer words sit at 0x00 and 0x04. Writes are stored, and reads return the stored word. Unmapped or misaligned addresses read zero, and writes to them are ignored.
- R2: While reset is asserted, every register reads zero and both wake_o and irq_o are low.
- R3: Pin p maps to bit (p mod 32) of word (p / 32) in every bank. Bits for pins at or above NUM_PINS always read zero.
- R4: Each pin passes through two synchronising flops. With its rising bit set, a low-to-high pin change sets the pin's status bit on the third clock edge after the change is first sampled. A high-to-low change does not count as a rising event.
- R5: With its falling bit set, a high-to-low change sets the status bit with the same latency. A low-to-high change does not count as a falling event. Both bits may be set together.
- R6: When both edge bits of a pin are clear, the pin is level sensed. Polarity 1 means high is active, and polarity 0 means low is active. Outside sleep the status bit follows the active level. While sleep is armed, it is sticky.
- R7: A host write to a status word sets it to the written value (masked per R3). On that edge the write takes priority over hardware capture.
- R8: irq_o is high exactly when some pin has both its status bit and its enable bit set.
- R9: A sleep_req_i cycle arms monitoring. While armed, the first enabled edge event or active level makes wake_o high for exactly one cycle, on the edge after the event is detected. The same edge disarms the block, and no further wake follows until the block is armed again.
- R10: A pin whose enable bit is clear still captures status but never raises wake_o or irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_pin_i | input | NUM_PINS | Asynchronous wakeup pins |
| sleep_req_i | input | 1 | Arms monitoring for sleep |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| wake_o | output | 1 | One-cycle wake request |
| irq_o | output | 1 | Enabled pending event indication |

## Verification
The assertions check on every cycle that the wake pulse lasts one cycle and follows an armed state, which it clears. They also check that no enable bits means no interrupt and no wake. They further check that status bits never drop while armed unless the host writes. The bench's scenarios show the rest: the exact three-edge capture latency, the choice between edge and level sensing per pin, the masking of unused bit lanes, and the priority of a host status write. A cycle-accurate reference model covers register read-back and output values over the whole run.

// File: rtl/slp_wake_pkg.sv
package slp_wake_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BANK_CNT  = 5;
  localparam int unsigned TIMER_CNT = 2;

  // Bank numbering: fixes the address layout
  localparam int unsigned BK_EN   = 0;
  localparam int unsigned BK_FALL = 1;
  localparam int unsigned BK_RISE = 2;
  localparam int unsigned BK_POL  = 3;
  localparam int unsigned BK_STAT = 4;

  function automatic int unsigned words_for(input int unsigned pins);
    return (pins + WORD_W - 1) / WORD_W;
  endfunction

  function automatic int unsigned timer_addr(input int unsigned t);
    return t * 4;
  endfunction

  function automatic int unsigned bank_word_addr(input int unsigned bank,
                                                 input int unsigned idx,
                                                 input int unsigned nw);
    return (bank * nw + idx + TIMER_CNT) * 4;
  endfunction

  // Lanes of word idx that correspond to real pins
  function automatic logic [WORD_W-1:0] lane_mask(input int unsigned idx,
                                                  input int unsigned pins);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int unsigned j = 0; j < WORD_W; j++) m[j] = ((idx * WORD_W + j) < pins);
    return m;
  endfunction
endpackage

// File: rtl/slp_pin_sync.sv
module slp_pin_sync #(
  parameter int unsigned NUM_PINS = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] lvl_o,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o
);
  logic [NUM_PINS-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_q & ~prev_q;
  assign fall_o = ~lvl_q & prev_q;
endmodule

// File: rtl/slp_trig_eval.sv
module slp_trig_eval #(
  parameter int unsigned NUM_PINS = 40
) (
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] rise_ev_i,
  input  logic [NUM_PINS-1:0] fall_ev_i,
  input  logic [NUM_PINS-1:0] rise_cfg_i,
  input  logic [NUM_PINS-1:0] fall_cfg_i,
  input  logic [NUM_PINS-1:0] pol_cfg_i,
  input  logic [NUM_PINS-1:0] en_i,
  input  logic [NUM_PINS-1:0] stat_i,
  input  logic                armed_i,
  output logic [NUM_PINS-1:0] stat_nxt_o,
  output logic                hit_o
);
  logic [NUM_PINS-1:0] raw_ev;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic edge_mode, edge_hit, lvl_act;
    assign edge_mode = rise_cfg_i[p] | fall_cfg_i[p];
    assign edge_hit  = (rise_cfg_i[p] & rise_ev_i[p]) | (fall_cfg_i[p] & fall_ev_i[p]);
    assign lvl_act   = pol_cfg_i[p] ? lvl_i[p] : ~lvl_i[p];
    assign raw_ev[p] = edge_mode ? edge_hit : lvl_act;
    // edge pins and armed level pins accumulate; idle level pins track
    assign stat_nxt_o[p] = (edge_mode | armed_i) ? (stat_i[p] | raw_ev[p]) : lvl_act;
  end

  assign hit_o = armed_i & (|(raw_ev & en_i));
endmodule

// File: rtl/slp_wake_regs.sv
module slp_wake_regs
  import slp_wake_pkg::*;
#(
  parameter int unsigned NUM_PINS = 40,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0] stat_hw_i,
  output logic [NUM_PINS-1:0] en_o,
  output logic [NUM_PINS-1:0] fall_o,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] pol_o,
  output logic [NUM_PINS-1:0] stat_o,
  output logic [WORD_W-1:0]   rdata_o
);
  localparam int unsigned NW   = words_for(NUM_PINS);
  localparam int unsigned FLAT = NW * WORD_W;

  logic [TIMER_CNT-1:0][WORD_W-1:0]        timer_w;
  logic [BANK_CNT-1:0][NW-1:0][WORD_W-1:0] bank_w;
  logic [FLAT-1:0]                         hw_pad;

  always_comb begin
    hw_pad = '0;
    hw_pad[NUM_PINS-1:0] = stat_hw_i;
  end

  for (genvar t = 0; t < TIMER_CNT; t++) begin : g_tmr
    logic [WORD_W-1:0] word_q;
    logic              sel;
    assign sel = wr_i && (addr_i == ADDR_W'(timer_addr(t)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (sel) word_q <= wdata_i;
    end
    assign timer_w[t] = word_q;
  end

  for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
    for (genvar i = 0; i < NW; i++) begin : g_word
      localparam logic [WORD_W-1:0] MASK = lane_mask(i, NUM_PINS);
      logic [WORD_W-1:0] word_q;
      logic              sel;
      assign sel = wr_i && (addr_i == ADDR_W'(bank_word_addr(b, i, NW)));
      if (b == BK_STAT) begin : g_stat
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   word_q <= '0;
          else if (sel) word_q <= wdata_i & MASK;
          else          word_q <= hw_pad[i*WORD_W +: WORD_W] & MASK;
        end
      end else begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   word_q <= '0;
          else if (sel) word_q <= wdata_i & MASK;
        end
      end
      assign bank_w[b][i] = word_q;
    end
  end

  always_comb begin
    for (int unsigned p = 0; p < NUM_PINS; p++) begin
      en_o[p]   = bank_w[BK_EN][p / WORD_W][p % WORD_W];
      fall_o[p] = bank_w[BK_FALL][p / WORD_W][p % WORD_W];
      rise_o[p] = bank_w[BK_RISE][p / WORD_W][p % WORD_W];
      pol_o[p]  = bank_w[BK_POL][p / WORD_W][p % WORD_W];
      stat_o[p] = bank_w[BK_STAT][p / WORD_W][p % WORD_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int unsigned t = 0; t < TIMER_CNT; t++)
      if (addr_i == ADDR_W'(timer_addr(t))) rdata_o = timer_w[t];
    for (int unsigned b = 0; b < BANK_CNT; b++)
      for (int unsigned i = 0; i < NW; i++)
        if (addr_i == ADDR_W'(bank_word_addr(b, i, NW))) rdata_o = bank_w[b][i];
  end
endmodule

// File: rtl/slp_wake_mon.sv
module slp_wake_mon #(
  parameter int unsigned NUM_PINS = 40,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] wake_pin_i,
  input  logic                sleep_req_i,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                wake_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] lvl_s, rise_s, fall_s;
  logic [NUM_PINS-1:0] en_q, fall_q, rise_q, pol_q, stat_q, stat_nxt;
  logic                armed_q, wake_q, hit;

  slp_pin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(wake_pin_i),
    .lvl_o(lvl_s), .rise_o(rise_s), .fall_o(fall_s)
  );

  slp_trig_eval #(.NUM_PINS(NUM_PINS)) u_eval (
    .lvl_i(lvl_s), .rise_ev_i(rise_s), .fall_ev_i(fall_s),
    .rise_cfg_i(rise_q), .fall_cfg_i(fall_q), .pol_cfg_i(pol_q),
    .en_i(en_q), .stat_i(stat_q), .armed_i(armed_q),
    .stat_nxt_o(stat_nxt), .hit_o(hit)
  );

  slp_wake_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .stat_hw_i(stat_nxt),
    .en_o(en_q), .fall_o(fall_q), .rise_o(rise_q), .pol_o(pol_q),
    .stat_o(stat_q), .rdata_o(reg_rdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= hit;
      if (hit)              armed_q <= 1'b0;
      else if (sleep_req_i) armed_q <= 1'b1;
    end
  end

  assign wake_o = wake_q;
  assign irq_o  = |(stat_q & en_q);
endmodule

// File: rtl/slp_wake_mon_chk.sv
module slp_wake_mon_chk #(
  parameter int unsigned NUM_PINS = 40
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wake_o,
  input logic                irq_o,
  input logic                reg_wr_i,
  input logic                armed,
  input logic [NUM_PINS-1:0] en,
  input logic [NUM_PINS-1:0] stat
);
  // R9
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  // R9
  wake_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ($past(armed) && !armed));

  // R10
  no_en_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq_o);

  // R10
  no_en_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !wake_o);

  // R6
  armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(armed) && !$past(reg_wr_i)) |-> ((stat & $past(stat)) == $past(stat)));
endmodule

bind slp_wake_mon slp_wake_mon_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wake_o(wake_o), .irq_o(irq_o),
  .reg_wr_i(reg_wr_i), .armed(armed_q), .en(en_q), .stat(stat_q)
);

// File: tb/slp_wake_mon_bench.sv
`timescale 1ns/1ps
module slp_wake_mon_bench;
  localparam int NP = 40;
  localparam int AW = 8;
  localparam int NWB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NP-1:0] pins = '0;
  logic          sleep = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  wire  [31:0]   rdata;
  wire           wake, irq;

  slp_wake_mon #(.NUM_PINS(NP), .ADDR_W(AW)) u_slp_wake_mon (
    .clk(clk), .rst_n(rst_n), .wake_pin_i(pins), .sleep_req_i(sleep),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .wake_o(wake), .irq_o(irq)
  );

  int total = 0, bad = 0, wake_cnt = 0, base = 0;

  // reference model state
  bit        m_s1[NP], m_s2[NP], m_pv[NP];
  bit        m_cfg[5][NP];
  bit [31:0] m_tmr[2];
  bit        m_armed, m_wake;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  function automatic bit m_irq();
    for (int p = 0; p < NP; p++) if (m_cfg[4][p] && m_cfg[0][p]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit [31:0] m_read(input int a);
    bit [31:0] r = '0;
    int w, k, b, i;
    if (a % 4 != 0) return '0;
    w = a / 4;
    if (w < 2) return m_tmr[w];
    k = w - 2;
    if (k >= 5 * NWB) return '0;
    b = k / NWB;
    i = k % NWB;
    for (int j = 0; j < 32; j++)
      if (i * 32 + j < NP) r[j] = m_cfg[b][i * 32 + j];
    return r;
  endfunction

  always @(posedge clk) begin : mstep
    bit nst[NP];
    bit hit;
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_s1[p] = 0; m_s2[p] = 0; m_pv[p] = 0;
        for (int b = 0; b < 5; b++) m_cfg[b][p] = 0;
      end
      m_tmr[0] = '0; m_tmr[1] = '0; m_armed = 0; m_wake = 0;
    end else begin
      hit = 0;
      for (int p = 0; p < NP; p++) begin
        bit up, dn, em, ev, act, raw;
        up  = m_s2[p] && !m_pv[p];
        dn  = !m_s2[p] && m_pv[p];
        em  = m_cfg[2][p] || m_cfg[1][p];
        ev  = (m_cfg[2][p] && up) || (m_cfg[1][p] && dn);
        act = m_cfg[3][p] ? m_s2[p] : !m_s2[p];
        raw = em ? ev : act;
        nst[p] = (em || m_armed) ? (m_cfg[4][p] || raw) : act;
        if (m_armed && raw && m_cfg[0][p]) hit = 1;
      end
      if (wr && (int'(addr) % 4 == 0)) begin
        int w;
        w = int'(addr) / 4;
        if (w < 2) m_tmr[w] = wdata;
        else if (w - 2 < 5 * NWB) begin
          int b, i;
          b = (w - 2) / NWB;
          i = (w - 2) % NWB;
          for (int j = 0; j < 32; j++) begin
            if (i * 32 + j < NP) begin
              if (b == 4) nst[i * 32 + j] = wdata[j];
              else        m_cfg[b][i * 32 + j] = wdata[j];
            end
          end
        end
      end
      for (int p = 0; p < NP; p++) begin
        m_cfg[4][p] = nst[p];
        m_pv[p] = m_s2[p];
        m_s2[p] = m_s1[p];
        m_s1[p] = pins[p];
      end
      m_wake = hit;
      if (hit) m_armed = 0;
      else if (sleep) m_armed = 1;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R1", rdata, m_read(int'(addr)));
      chk("R8", {31'b0, irq}, {31'b0, m_irq()});
      chk("R9", {31'b0, wake}, {31'b0, m_wake});
      if (wake) wake_cnt++;
    end
  end

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] m, input logic [31:0] e);
    @(negedge clk);
    addr = AW'(a);
    #1;
    chk(req, rdata & m, e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm();
    @(negedge clk); sleep = 1'b1;
    @(negedge clk); sleep = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R2: reset state at every mapped address
    #1;
    for (int a = 0; a < 48; a += 4) begin
      addr = AW'(a);
      #0.2;
      chk("R2", rdata, 32'h0);
    end
    chk("R2", {30'b0, wake, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R3: map and lanes
    wr_reg(32'h00, 32'hDEADBEEF);
    wr_reg(32'h04, 32'h12345678);
    wr_reg(32'h20, 32'hA5A5A5A5);
    wr_reg(32'h0C, 32'hFFFFFFFF);
    rd_chk("R1", 32'h00, 32'hFFFFFFFF, 32'hDEADBEEF);
    rd_chk("R1", 32'h04, 32'hFFFFFFFF, 32'h12345678);
    rd_chk("R1", 32'h20, 32'hFFFFFFFF, 32'hA5A5A5A5);
    rd_chk("R3", 32'h0C, 32'hFFFFFFFF, 32'h000000FF);
    rd_chk("R1", 32'h30, 32'hFFFFFFFF, 32'h0);
    rd_chk("R1", 32'h21, 32'hFFFFFFFF, 32'h0);
    wr_reg(32'h0C, 32'h0);
    wr_reg(32'h20, 32'h0);

    // configure: pin3 rising, pin35 falling, pin5 level-high
    wr_reg(32'h18, 32'h00000008);
    wr_reg(32'h14, 32'h00000008);
    wr_reg(32'h20, 32'h00000020);
    wr_reg(32'h08, 32'h00000028);
    wr_reg(32'h0C, 32'h00000008);
    wr_reg(32'h28, 32'h0);
    wr_reg(32'h2C, 32'h0);
    idle(1);
    #1 chk("R8", {31'b0, irq}, 32'h0);

    // R4: rising capture latency, no wake while unarmed
    @(negedge clk); pins[3] = 1'b1; addr = 8'h28;
    @(negedge clk);
    @(negedge clk); #1 chk("R4", rdata & 32'h8, 32'h0);
    @(negedge clk); #1 chk("R4", rdata & 32'h8, 32'h8);
    chk("R8", {31'b0, irq}, 32'h1);
    chk("R9", {31'b0, wake}, 32'h0);
    wr_reg(32'h28, 32'h0);
    #1 chk("R8", {31'b0, irq}, 32'h0);

    // R9 with R4/R5 negative cases
    arm();
    base = wake_cnt;
    @(negedge clk); pins[3] = 1'b0;
    idle(4);
    chk("R4", wake_cnt, base);
    @(negedge clk); pins[35] = 1'b1;
    idle(4);
    chk("R5", wake_cnt, base);
    @(negedge clk); pins[35] = 1'b0; addr = 8'h2C;
    @(negedge clk);
    @(negedge clk); #1 chk("R9", {31'b0, wake}, 32'h0);
    @(negedge clk); #1 chk("R9", {31'b0, wake}, 32'h1);
    chk("R5", rdata & 32'h8, 32'h8);
    @(negedge clk); #1 chk("R9", {31'b0, wake}, 32'h0);
    @(negedge clk); pins[3] = 1'b1;
    idle(5);
    chk("R9", wake_cnt, base + 1);
    chk("R8", {31'b0, irq}, 32'h1);

    // R10: disabled pin captures but never signals
    wr_reg(32'h18, 32'h00000408);
    wr_reg(32'h28, 32'h0);
    wr_reg(32'h2C, 32'h0);
    arm();
    base = wake_cnt;
    @(negedge clk); pins[10] = 1'b1;
    idle(5);
    chk("R10", wake_cnt, base);
    chk("R10", {31'b0, irq}, 32'h0);
    rd_chk("R10", 32'h28, 32'h400, 32'h400);

    // R6: level pin sticky while armed
    wr_reg(32'h08, 32'h00000008);
    @(negedge clk); pins[5] = 1'b1;
    idle(4);
    @(negedge clk); pins[5] = 1'b0;
    idle(4);
    rd_chk("R6", 32'h28, 32'h20, 32'h20);
    chk("R6", wake_cnt, base);
    wr_reg(32'h08, 32'h00000028);
    @(negedge clk); pins[5] = 1'b1;
    idle(5);
    chk("R9", wake_cnt, base + 1);
    @(negedge clk); pins[5] = 1'b0;
    idle(4);
    rd_chk("R6", 32'h28, 32'h20, 32'h0);

    // R7: status write takes the written value, unused lanes masked
    wr_reg(32'h2C, 32'hFFFF00F0);
    addr = 8'h2C;
    #1 chk("R7", rdata, 32'h000000F0);

    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule